// File: doc/BRIEF.md
# SPI Slave Command-Packet Engine

This block is the host-facing end of a peripheral. A host talks to it over a four-wire serial link with an active-low chip select, a serial clock that idles low, a data line in and a data line out. Every transaction opens with a 32-bit command word. The command picks the direction, the address mode, a target function, a start address and a byte length. A burst of data words then follows, either written into or read out of a simple synchronous address/data/strobe bus behind the block.

The serial pins are sampled in the system clock domain through a short synchronizer, and the engine acts on the detected edges. Function 0 is served inside the block. It holds a small control word that selects the word size (16 or 32 bits), the byte order within a word and a wake-up request. Functions 1 to 3 go out on the back bus, and only after the wake-up request has been set and acknowledged. Before that, the engine accepts transfers to these functions and drops them.

Top module: `spi_cmd_engine`

## Requirements
- R1: The first 32 bits after chip select goes low are the command, taken MSB first on rising SCLK edges. Bit 31 is the direction (1 = write, 0 = read), bit 30 is auto-increment, bits 29:28 are the function, bits 27:11 are the 17-bit byte address and bits 10:0 are the byte length. The function appears on `bus_fn` with each bus strobe.
- R2: A burst holds ceil(bytes / word bytes) words, where a word is 2 bytes in 16-bit mode and 4 bytes in 32-bit mode. A length field of 0 means 2048 bytes.
- R3: On a write, each completed data word gives exactly one single-cycle `bus_wr` pulse carrying the function, address and data. In 16-bit mode the data sits in bits 15:0 and bits 31:16 are zero. `bus_wr` and `bus_rd` never pulse in the same cycle.
- R4: On a read, each word gives one `bus_rd` pulse. `bus_rdata` is taken in the cycle after the pulse. The first data bit is driven after the falling SCLK edge that follows the last command bit, so the host samples it on rising edge 33. Bits go out MSB first, and each following word follows at once.
- R5: With byte order 0, the serial word (MSB first) equals the bus word. With byte order 1, the bytes are reversed within the word: 2 bytes in 16-bit mode, 4 bytes in 32-bit mode. This holds for both directions.
- R6: With auto-increment set, the address advances by the word size in bytes after each word and wraps within 17 bits. With it clear, every word uses the start address.
- R7: Function 0 reaches the internal control word and never the bus. In the control word, bit 0 selects 32-bit mode, bit 1 selects byte order 1, bit 2 is the wake-up request and bit 3 reads back the ready flag (read only). The word resets to 0. Word size and byte order are latched at each command, so a change applies from the next command on.
- R8: `wake_out` follows the wake-up bit. `ready` rises only after the wake-up bit is set and `wake_ack` is high. While `ready` is low, transfers to functions 1 to 3 give no bus strobe and read data is all zeros.
- R9: Raising chip select during a transfer aborts it. A partial word is discarded, no further strobe is issued, and the next low period of chip select starts with a new command.
- R10: `spi_miso_oe` is high only while chip select is low (after the synchronizer), and `spi_miso` is 0 while the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| wake_out | output | 1 | Wake-up request to the function behind the bus |
| wake_ack | input | 1 | Acknowledge of the wake-up request |
| ready | output | 1 | Transfers to functions 1 to 3 take effect |
| bus_fn | output | 2 | Function of the current bus access |
| bus_addr | output | 17 | Byte address of the current bus access |
| bus_wdata | output | 32 | Write data |
| bus_wr | output | 1 | Write strobe, one cycle |
| bus_rd | output | 1 | Read strobe, one cycle |
| bus_rdata | input | 32 | Read data, valid the cycle after `bus_rd` |

## Verification
The hardest cases are a chip select that rises partway through a data word and the maximum burst that a zero length field selects. Neither shows up in short, well-formed transfers. The bench's transaction task stops clocking after a chosen total bit count, which it places inside the command and inside a data word. It then follows each abort with a clean transfer to prove that the engine has resynchronized. The 2048-byte burst runs with a faster serial clock, and the bench checks the strobe count, the final incremented address and the final data word.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int FN_W   = 2;
    localparam int ADDR_W = 17;
    localparam int LEN_W  = 11;
    localparam int DATA_W = 32;
    localparam int CMD_W  = 2 + FN_W + ADDR_W + LEN_W;
    localparam int CNT_W  = LEN_W + 1;
    localparam int BC_W   = $clog2(CMD_W);

    typedef struct packed {
        logic              wr;
        logic              inc;
        logic [FN_W-1:0]   fn;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } cmd_t;

    // bit 0 = 32-bit mode, bit 1 = byte order, bit 2 = wake request
    typedef struct packed {
        logic wake;
        logic swap;
        logic w32;
    } cfg_t;

    typedef enum logic [1:0] {ST_CMD, ST_WDATA, ST_RDATA, ST_DONE} st_t;
    typedef enum logic [1:0] {RD_ZERO, RD_CFG, RD_BUS} rd_src_t;

    function automatic logic [CNT_W-1:0] word_count(input logic [LEN_W-1:0] len,
                                                    input logic w32);
        logic [CNT_W-1:0] bytes;
        bytes = (len == '0) ? (CNT_W'(1) << LEN_W) : CNT_W'(len);
        return w32 ? ((bytes + CNT_W'(3)) >> 2) : ((bytes + CNT_W'(1)) >> 1);
    endfunction

    function automatic logic [ADDR_W-1:0] addr_step(input logic w32);
        return w32 ? ADDR_W'(4) : ADDR_W'(2);
    endfunction

    // Byte ordering between the serial word and the bus word (an involution)
    function automatic logic [DATA_W-1:0] fmt_word(input logic [DATA_W-1:0] w,
                                                   input logic w32,
                                                   input logic swap);
        if (w32)
            return swap ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        else
            return swap ? {16'h0, w[7:0], w[15:8]} : {16'h0, w[15:0]};
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic csn,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s,
    output logic cs_act
);
    logic [STAGES-1:0] sck_p, csn_p, mosi_p;
    logic              sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p  <= '0;
            mosi_p <= '0;
            csn_p  <= '1;
            sck_d  <= 1'b0;
        end else begin
            sck_p  <= {sck_p[STAGES-2:0], sclk};
            mosi_p <= {mosi_p[STAGES-2:0], mosi};
            csn_p  <= {csn_p[STAGES-2:0], csn};
            sck_d  <= sck_p[STAGES-1];
        end
    end

    assign cs_act    = ~csn_p[STAGES-1];
    assign mosi_s    = mosi_p[STAGES-1];
    assign sclk_rise = cs_act &  sck_p[STAGES-1] & ~sck_d;
    assign sclk_fall = cs_act & ~sck_p[STAGES-1] &  sck_d;

    AST_RISE_PULSE: assert property (@(posedge clk) disable iff (rst)
        sclk_rise |=> !sclk_rise);  // R4

endmodule

// File: rtl/spi_wake_ctl.sv
module spi_wake_ctl
    import spi_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_we,
    input  cfg_t cfg_wdata,
    input  logic wake_ack,
    output cfg_t cfg,
    output logic ready,
    output logic wake_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            ready <= 1'b0;
        end else begin
            if (cfg_we)
                cfg <= cfg_wdata;
            ready <= cfg.wake & wake_ack;
        end
    end

    assign wake_out = cfg.wake;

    AST_READY_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(wake_ack));  // R8

endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic              cs_act,
    input  cfg_t              cfg,
    input  logic              ready,
    output logic              cfg_we,
    output cfg_t              cfg_wdata,
    output logic [FN_W-1:0]   bus_fn,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              miso_bit
);
    st_t               st;
    logic [DATA_W-2:0] sh_in;
    logic [DATA_W-1:0] sh_out, hold;
    logic [BC_W-1:0]   bitcnt;
    logic [FN_W-1:0]   fn_q;
    logic              inc_q, m32, swp, load_pend, rd_req_q, rd_cap;
    logic [CNT_W-1:0]  left;
    logic [ADDR_W-1:0] addr_q;
    rd_src_t           src_q;

    logic [DATA_W-1:0] shifted, wr_word, rd_val, rd_word, rd_aligned;
    cmd_t              cmd_new;
    logic              last_bit;

    always_comb begin
        shifted  = {sh_in, mosi_s};
        cmd_new  = cmd_t'(shifted);
        wr_word  = fmt_word(shifted, m32, swp);
        last_bit = (bitcnt == (m32 ? BC_W'(DATA_W-1) : BC_W'(DATA_W/2-1)));
        case (src_q)
            RD_BUS:  rd_val = bus_rdata;
            RD_CFG:  rd_val = DATA_W'({ready, cfg});
            default: rd_val = '0;
        endcase
        rd_word    = fmt_word(rd_val, m32, swp);
        rd_aligned = m32 ? rd_word : {rd_word[15:0], 16'h0};
    end

    always_ff @(posedge clk) begin
        bus_wr   <= 1'b0;
        rd_req_q <= 1'b0;
        cfg_we   <= 1'b0;
        rd_cap   <= rd_req_q;
        if (rst) begin
            st        <= ST_CMD;
            sh_in     <= '0;
            sh_out    <= '0;
            hold      <= '0;
            bitcnt    <= '0;
            fn_q      <= '0;
            inc_q     <= 1'b0;
            m32       <= 1'b0;
            swp       <= 1'b0;
            load_pend <= 1'b0;
            left      <= '0;
            addr_q    <= '0;
            src_q     <= RD_ZERO;
            cfg_wdata <= '0;
            bus_fn    <= '0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            rd_cap    <= 1'b0;
        end else if (!cs_act) begin
            st        <= ST_CMD;
            sh_in     <= '0;
            sh_out    <= '0;
            bitcnt    <= '0;
            load_pend <= 1'b0;
        end else begin
            if (sclk_rise) begin
                case (st)
                    ST_CMD: begin
                        sh_in  <= shifted[DATA_W-2:0];
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == BC_W'(CMD_W-1)) begin
                            bitcnt <= '0;
                            fn_q   <= cmd_new.fn;
                            inc_q  <= cmd_new.inc;
                            m32    <= cfg.w32;
                            swp    <= cfg.swap;
                            left   <= word_count(cmd_new.len, cfg.w32);
                            if (cmd_new.wr) begin
                                st     <= ST_WDATA;
                                addr_q <= cmd_new.addr;
                            end else begin
                                st        <= ST_RDATA;
                                rd_req_q  <= 1'b1;
                                load_pend <= 1'b1;
                                bus_fn    <= cmd_new.fn;
                                bus_addr  <= cmd_new.addr;
                                src_q     <= (cmd_new.fn == '0) ? RD_CFG :
                                             (ready ? RD_BUS : RD_ZERO);
                                addr_q    <= cmd_new.inc ? cmd_new.addr + addr_step(cfg.w32)
                                                         : cmd_new.addr;
                            end
                        end
                    end
                    ST_WDATA: begin
                        sh_in  <= shifted[DATA_W-2:0];
                        bitcnt <= bitcnt + 1'b1;
                        if (last_bit) begin
                            bitcnt <= '0;
                            if (fn_q == '0) begin
                                cfg_we    <= 1'b1;
                                cfg_wdata <= cfg_t'(wr_word[2:0]);
                            end else if (ready) begin
                                bus_wr    <= 1'b1;
                                bus_fn    <= fn_q;
                                bus_addr  <= addr_q;
                                bus_wdata <= wr_word;
                            end
                            if (inc_q)
                                addr_q <= addr_q + addr_step(m32);
                            left <= left - 1'b1;
                            if (left == CNT_W'(1))
                                st <= ST_DONE;
                        end
                    end
                    ST_RDATA: begin
                        bitcnt <= bitcnt + 1'b1;
                        if (last_bit) begin
                            bitcnt <= '0;
                            left   <= left - 1'b1;
                            if (left == CNT_W'(1)) begin
                                st <= ST_DONE;
                            end else begin
                                rd_req_q  <= 1'b1;
                                load_pend <= 1'b1;
                                bus_fn    <= fn_q;
                                bus_addr  <= addr_q;
                                src_q     <= (fn_q == '0) ? RD_CFG :
                                             (ready ? RD_BUS : RD_ZERO);
                                if (inc_q)
                                    addr_q <= addr_q + addr_step(m32);
                            end
                        end
                    end
                    default: ;
                endcase
            end
            if (sclk_fall) begin
                if (load_pend) begin
                    sh_out    <= hold;
                    load_pend <= 1'b0;
                end else begin
                    sh_out <= {sh_out[DATA_W-2:0], 1'b0};
                end
            end
            if (rd_cap)
                hold <= rd_aligned;
        end
    end

    assign bus_rd   = rd_req_q && (src_q == RD_BUS);
    assign miso_bit = sh_out[DATA_W-1];

    AST_WR_GATED: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> $past(ready));  // R8
    AST_RD_GATED: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> $past(ready));  // R8
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd));  // R3
    AST_FN0_LOCAL: assert property (@(posedge clk) disable iff (rst)
        (bus_wr || bus_rd) |-> (bus_fn != '0));  // R7
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (!bus_wr && !rd_req_q));  // R9

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              wake_out,
    input  logic              wake_ack,
    output logic              ready,
    output logic [FN_W-1:0]   bus_fn,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata
);
    logic sclk_rise, sclk_fall, mosi_s, cs_act, cfg_we, miso_bit;
    cfg_t cfg, cfg_wdata;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sclk(spi_sclk), .csn(spi_csn), .mosi(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s), .cs_act(cs_act)
    );

    spi_wake_ctl u_wake (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .wake_ack(wake_ack), .cfg(cfg), .ready(ready), .wake_out(wake_out)
    );

    spi_cmd_fsm u_fsm (
        .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .mosi_s(mosi_s), .cs_act(cs_act), .cfg(cfg), .ready(ready),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .bus_fn(bus_fn), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .miso_bit(miso_bit)
    );

    assign spi_miso_oe = cs_act;
    assign spi_miso    = cs_act & miso_bit;

endmodule

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;
    logic clk = 1'b0, rst = 1'b1;
    logic spi_sclk = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0, wake_ack = 1'b0;
    logic spi_miso, spi_miso_oe, wake_out, ready, bus_wr, bus_rd;
    logic [1:0]  bus_fn;
    logic [16:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    always #2 clk = ~clk;

    spi_cmd_engine u_spi_cmd_engine (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .wake_out(wake_out),
        .wake_ack(wake_ack), .ready(ready), .bus_fn(bus_fn), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    int nchk = 0, nerr = 0, wcount = 0, rcount = 0;
    bit finished = 0;
    logic [1:0]  wl_fn   [64];
    logic [16:0] wl_addr [64];
    logic [31:0] wl_data [64];
    logic [16:0] rl_addr [64];
    logic [16:0] wl_last_addr;
    logic [31:0] wl_last_data;
    logic [31:0] rx_words [16];
    logic cur_w32 = 1'b0, cur_swap = 1'b0;

    function automatic logic [31:0] mem_val(input logic [1:0] fn, input logic [16:0] a);
        return {4'hA, 2'b00, fn, 7'h00, a};
    endfunction

    always_ff @(posedge clk) begin
        if (bus_rd) begin
            bus_rdata <= mem_val(bus_fn, bus_addr);
            if (rcount < 64) rl_addr[rcount] <= bus_addr;
            rcount <= rcount + 1;
        end
        if (bus_wr) begin
            if (wcount < 64) begin
                wl_fn[wcount] <= bus_fn; wl_addr[wcount] <= bus_addr; wl_data[wcount] <= bus_wdata;
            end
            wl_last_addr <= bus_addr;
            wl_last_data <= bus_wdata;
            wcount <= wcount + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] reorder(input logic [31:0] w, input logic w32, input logic swap);
        if (!w32) w = {16'h0, w[15:0]};
        if (!swap) return w;
        return w32 ? {w[7:0], w[15:8], w[23:16], w[31:24]} : {16'h0, w[7:0], w[15:8]};
    endfunction

    function automatic logic [31:0] tx_word(input logic [31:0] seed, input int k, input int wbits);
        logic [31:0] v;
        v = seed + 32'(k) * 32'h01020305;
        return (wbits == 32) ? v : {16'h0, v[15:0]};
    endfunction

    function automatic int nwords(input logic [10:0] len, input logic w32);
        int bytes;
        bytes = (len == 0) ? 2048 : int'(len);
        return w32 ? (bytes + 3) / 4 : (bytes + 1) / 2;
    endfunction

    function automatic logic [31:0] mk_cmd(input logic wr, input logic inc, input logic [1:0] fn,
                                           input logic [16:0] a, input logic [10:0] len);
        return {wr, inc, fn, a, len};
    endfunction

    task automatic spi_bit(input logic mo, output logic mi, input int half);
        spi_mosi = mo;
        repeat (half) @(negedge clk);
        spi_sclk = 1'b1;
        mi = spi_miso;
        repeat (half) @(negedge clk);
        spi_sclk = 1'b0;
    endtask

    // stop_bits < 0: complete transfer; otherwise chip select rises after that many bits
    task automatic spi_txn(input logic [31:0] cmd, input int n, input int wbits,
                           input logic [31:0] seed, input int half, input int stop_bits);
        int tot = 0;
        logic mi;
        logic [31:0] w, rxw;
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (half) @(negedge clk);
        for (int b = 31; b >= 0; b--) begin
            if (stop_bits < 0 || tot < stop_bits) begin
                spi_bit(cmd[b], mi, half);
                tot++;
            end
        end
        for (int k = 0; k < n; k++) begin
            w = tx_word(seed, k, wbits);
            rxw = '0;
            for (int b = wbits - 1; b >= 0; b--) begin
                if (stop_bits < 0 || tot < stop_bits) begin
                    spi_bit(w[b], mi, half);
                    rxw[b] = mi;
                    tot++;
                end
            end
            if (k < 16) rx_words[k] = rxw;
        end
        repeat (half) @(negedge clk);
        spi_csn = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [31:0] val);
        spi_txn(mk_cmd(1'b1, 1'b0, 2'd0, 17'h0, cur_w32 ? 11'd4 : 11'd2), 1, cur_w32 ? 32 : 16,
                reorder(val, cur_w32, cur_swap), 5, -1);
        cur_w32 = val[0];
        cur_swap = val[1];
    endtask

    task automatic cfg_read(output logic [31:0] val);
        spi_txn(mk_cmd(1'b0, 1'b0, 2'd0, 17'h0, cur_w32 ? 11'd4 : 11'd2), 1, cur_w32 ? 32 : 16,
                32'h0, 5, -1);
        val = reorder(rx_words[0], cur_w32, cur_swap);
    endtask

    typedef struct packed {
        logic        w32;
        logic        swap;
        logic        wr;
        logic        inc;
        logic [1:0]  fn;
        logic [16:0] addr;
        logic [10:0] len;
        logic [31:0] seed;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 17'h00100, 11'd6,  32'h1234ABCD},
        '{1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 17'h1FFFE, 11'd4,  32'hBEEF0123},
        '{1'b1, 1'b0, 1'b1, 1'b1, 2'd3, 17'h00040, 11'd8,  32'hCAFE5A01},
        '{1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 17'h00800, 11'd6,  32'h89ABCDEF},
        '{1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 17'h00010, 11'd4,  32'h0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 17'h00002, 11'd8,  32'h0},
        '{1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 17'h12345, 11'd2,  32'h0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 17'h1FFF8, 11'd12, 32'h0}
    };

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int w0, r0, n, wb;
        logic [16:0] a;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // reset state
        chk("R8", "wake_out after reset", 32'(wake_out), 32'd0);
        chk("R8", "ready after reset", 32'(ready), 32'd0);
        chk("R10", "miso_oe with cs high", 32'(spi_miso_oe), 32'd0);
        chk("R3", "bus_wr after reset", 32'(bus_wr), 32'd0);
        cfg_read(v);
        chk("R7", "control word reset value", v, 32'h0);

        // not ready: transfers to function 1 dropped
        wake_ack = 1'b1;
        w0 = wcount; r0 = rcount;
        spi_txn(mk_cmd(1, 0, 2'd1, 17'h20, 11'd2), 1, 16, 32'h5555, 5, -1);
        chk("R8", "write before wake", 32'(wcount - w0), 32'd0);
        spi_txn(mk_cmd(0, 0, 2'd1, 17'h20, 11'd2), 1, 16, 32'h0, 5, -1);
        chk("R8", "read strobe before wake", 32'(rcount - r0), 32'd0);
        chk("R8", "read data before wake", rx_words[0], 32'h0);

        // wake without acknowledge
        wake_ack = 1'b0;
        cfg_write(32'h4);
        chk("R8", "wake_out set", 32'(wake_out), 32'd1);
        cfg_read(v);
        chk("R7", "control readback without ack", v, 32'h4);
        w0 = wcount;
        spi_txn(mk_cmd(1, 0, 2'd1, 17'h20, 11'd2), 1, 16, 32'h5555, 5, -1);
        chk("R8", "write while unacknowledged", 32'(wcount - w0), 32'd0);
        wake_ack = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8", "ready after ack", 32'(ready), 32'd1);
        cfg_read(v);
        chk("R8", "control readback ready bit", v, 32'hC);

        // vector table
        for (int i = 0; i < 8; i++) begin
            cfg_write({29'h0, 1'b1, VECS[i].swap, VECS[i].w32});
            n  = nwords(VECS[i].len, VECS[i].w32);
            wb = VECS[i].w32 ? 32 : 16;
            w0 = wcount; r0 = rcount;
            spi_txn(mk_cmd(VECS[i].wr, VECS[i].inc, VECS[i].fn, VECS[i].addr, VECS[i].len),
                    n, wb, VECS[i].seed, 5, -1);
            for (int k = 0; k < n; k++) begin
                a = VECS[i].addr + (VECS[i].inc ? 17'(k * (wb / 8)) : 17'h0);
                if (VECS[i].wr) begin
                    chk(VECS[i].swap ? "R5" : "R3", $sformatf("vec%0d wdata%0d", i, k),
                        wl_data[w0 + k], reorder(tx_word(VECS[i].seed, k, wb), VECS[i].w32, VECS[i].swap));
                    chk("R6", $sformatf("vec%0d waddr%0d", i, k), 32'(wl_addr[w0 + k]), 32'(a));
                    chk("R1", $sformatf("vec%0d wfn%0d", i, k), 32'(wl_fn[w0 + k]), 32'(VECS[i].fn));
                end else begin
                    chk(VECS[i].swap ? "R5" : "R4", $sformatf("vec%0d rdata%0d", i, k),
                        rx_words[k], reorder(mem_val(VECS[i].fn, a), VECS[i].w32, VECS[i].swap));
                    chk("R6", $sformatf("vec%0d raddr%0d", i, k), 32'(rl_addr[r0 + k]), 32'(a));
                end
            end
            if (VECS[i].wr)
                chk("R2", $sformatf("vec%0d write count", i), 32'(wcount - w0), 32'(n));
            else
                chk("R2", $sformatf("vec%0d read count", i), 32'(rcount - r0), 32'(n));
        end

        // chip-select enable window
        cfg_write(32'h4);
        @(negedge clk); spi_csn = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10", "miso_oe with cs low", 32'(spi_miso_oe), 32'd1);
        spi_csn = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10", "miso_oe after cs high", 32'(spi_miso_oe), 32'd0);
        chk("R10", "miso level with oe low", 32'(spi_miso), 32'd0);

        // abort inside second data word
        w0 = wcount;
        spi_txn(mk_cmd(1, 1, 2'd1, 17'h200, 11'd6), 3, 16, 32'h0000A1B2, 5, 32 + 16 + 8);
        chk("R9", "abort mid word count", 32'(wcount - w0), 32'd1);
        chk("R9", "abort first word kept", wl_data[w0], 32'h0000A1B2);
        // abort inside command
        w0 = wcount;
        spi_txn(mk_cmd(1, 1, 2'd1, 17'h200, 11'd6), 3, 16, 32'h0000A1B2, 5, 20);
        chk("R9", "abort in command count", 32'(wcount - w0), 32'd0);
        w0 = wcount;
        spi_txn(mk_cmd(1, 0, 2'd2, 17'h300, 11'd2), 1, 16, 32'h00007E81, 5, -1);
        chk("R9", "clean transfer after abort count", 32'(wcount - w0), 32'd1);
        chk("R9", "clean transfer after abort addr", 32'(wl_addr[w0]), 32'h300);

        // address wrap in 17 bits
        w0 = wcount;
        spi_txn(mk_cmd(1, 1, 2'd3, 17'h1FFFE, 11'd4), 2, 16, 32'h00001111, 5, -1);
        chk("R6", "wrap addr0", 32'(wl_addr[w0]), 32'h1FFFE);
        chk("R6", "wrap addr1", 32'(wl_addr[w0 + 1]), 32'h0);

        // zero length = 2048 bytes, 32-bit words
        cfg_write(32'h5);
        w0 = wcount;
        spi_txn(mk_cmd(1, 1, 2'd1, 17'h01000, 11'd0), 512, 32, 32'h31415926, 2, -1);
        chk("R2", "zero length word count", 32'(wcount - w0), 32'd512);
        chk("R6", "zero length last addr", 32'(wl_last_addr), 32'h017FC);
        chk("R3", "zero length last data", wl_last_data, tx_word(32'h31415926, 511, 32));

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule